// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from eight independent lines and turns them into one interrupt signal for a processor. A request is taken from a rising edge on its line after that line passes through a synchronizer. Each line can be masked. Among the unmasked pending lines, the one with the lowest number wins. When the processor acknowledges, the block returns an 8-bit vector. The vector is a programmable base plus the winning line number.

Acknowledging a line moves it from pending to in-service. While a line is in service, it holds off every line of the same or lower priority. Lines of higher priority can still interrupt. An end-of-service pulse retires the most urgent in-service line. The processor writes the mask and the vector base through a small write-only register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq` and `vec_valid` are low, no line is masked, nothing is pending or in service, and the vector base is 8.
- R2: The returned vector equals base plus line number, modulo 256. With base 8, line 1 returns 9. With base 0xFC, line 7 returns 0x03.
- R3: A masked line never raises `cpu_irq`. Its captured request stays pending, and it raises `cpu_irq` once it is unmasked.
- R4: `vec_valid` is high for exactly the one cycle after a cycle in which `int_ack` and `cpu_irq` were both high, and `vec_out` holds the vector in that cycle. An `int_ack` while `cpu_irq` is low is ignored.
- R5: Line 0 has the highest priority and line 7 the lowest. When several eligible lines are pending, the lowest-numbered one is served first.
- R6: An acknowledge clears the pending request of the served line and puts that line in service. The line does not request again without a new rising edge.
- R7: A line in service blocks `cpu_irq` for lines of equal or lower priority. A pending unmasked line of higher priority still raises `cpu_irq`.
- R8: An `eos` pulse removes only the highest-priority line from the in-service set.
- R9: A request is captured on a rising edge of its input. `cpu_irq` rises on the third clock edge after the input rises, with the default two synchronizer stages. A line held high does not request again.
- R10: A write with `cfg_we` high and `cfg_sel` 0 loads the mask from `cfg_wdata`, where bit i set masks line i. A write with `cfg_sel` 1 loads the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Asynchronous request lines, bit i is line i |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 mask, 1 vector base |
| cfg_wdata | input | 8 | Register write data |
| cpu_irq | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge from the processor, one-cycle pulse |
| vec_out | output | 8 | Vector of the acknowledged line |
| vec_valid | output | 1 | `vec_out` valid, one cycle after an accepted acknowledge |
| eos | input | 1 | End-of-service pulse |

## Verification
The bench builds the block with its default parameters: eight lines, an 8-bit vector, two synchronizer stages and a reset base of 8. At these values the bench can check that line 1 returns vector 9 straight after reset. It can also check that the latency from an input edge to `cpu_irq` is exactly three edges. The 8-bit vector width lets the bench drive a base of 0xFC and check that the vector wraps. With eight lines, the bench can build nested in-service sets such as lines 1 and 4. In those sets a wrong end-of-service choice changes whether line 2 is able to interrupt.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_LINES = 8,
  parameter int VEC_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] RESET_BASE = VEC_W'(8),
  localparam int IDX_W = $clog2(N_LINES + 1),
  localparam int CFG_W = (N_LINES > VEC_W) ? N_LINES : VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               cpu_irq,
  input  logic               int_ack,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  input  logic               eos
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = IDX_W'(N_LINES);
    for (int i = N_LINES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [N_LINES-1:0] sync_q [SYNC_STAGES];
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] pend_q, mask_q, isr_q;
  logic [VEC_W-1:0]   base_q, vec_q;
  logic               vec_valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= irq_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  logic [N_LINES-1:0] rise;
  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  logic [N_LINES-1:0] elig;
  logic [IDX_W-1:0]   elig_top, isr_top;
  assign elig     = pend_q & ~mask_q;
  assign elig_top = lowest_set(elig);
  assign isr_top  = lowest_set(isr_q);
  assign cpu_irq  = elig_top < isr_top;

  logic               take;
  logic [N_LINES-1:0] take_oh, eos_clr;
  assign take    = int_ack && cpu_irq;
  assign take_oh = take ? (N_LINES'(1) << elig_top) : '0;
  assign eos_clr = (eos && isr_top != IDX_W'(N_LINES)) ? (N_LINES'(1) << isr_top) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= '0;
      isr_q       <= '0;
      mask_q      <= '0;
      base_q      <= RESET_BASE;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      pend_q      <= (pend_q & ~take_oh) | rise;
      isr_q       <= (isr_q & ~eos_clr) | take_oh;
      vec_valid_q <= take;
      if (take) vec_q <= base_q + VEC_W'(elig_top);
      if (cfg_we) begin
        if (cfg_sel) base_q <= cfg_wdata[VEC_W-1:0];
        else         mask_q <= cfg_wdata[N_LINES-1:0];
      end
    end
  end

  assign vec_out   = vec_q;
  assign vec_valid = vec_valid_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_irq,
  input logic               int_ack,
  input logic               eos,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_out,
  input logic [VEC_W-1:0]   base_q,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] isr_q
);

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack && cpu_irq)); // R4

  AST_STRAY_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !cpu_irq) |=> !vec_valid); // R4

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (VEC_W'(vec_out - $past(base_q)) < VEC_W'(N_LINES))); // R2

  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((pend_q & ~mask_q) != '0)); // R3

  AST_ACK_SETS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && cpu_irq) |=> (isr_q != '0)); // R6

  AST_EOS_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !(int_ack && cpu_irq) && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q)))); // R8

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .int_ack(int_ack), .eos(eos),
  .vec_valid(vec_valid), .vec_out(vec_out), .base_q(base_q), .pend_q(pend_q),
  .mask_q(mask_q), .isr_q(isr_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq_in = '0, cfg_wdata = '0, vec_out;
  logic cfg_we = 0, cfg_sel = 0, int_ack = 0, eos = 0, cpu_irq, vec_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cpu_irq(cpu_irq), .int_ack(int_ack),
    .vec_out(vec_out), .vec_valid(vec_valid), .eos(eos));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_lines(input logic [7:0] m);
    irq_in = irq_in | m; tick(3);
    irq_in = irq_in & ~m; tick(1);
  endtask

  task automatic ack_expect(input int exp, input string req);
    int_ack = 1; tick(1); int_ack = 0;
    check(vec_valid === 1'b1, {req, " vec_valid"}, int'(vec_valid), 1);
    check(vec_out === 8'(exp), {req, " vector"}, int'(vec_out), exp);
    tick(1);
    check(vec_valid === 1'b0, "R4 single-cycle valid", int'(vec_valid), 0);
  endtask

  task automatic end_service();
    eos = 1; tick(1); eos = 0;
  endtask

  task automatic write_cfg(input logic sel, input logic [7:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1; tick(1); cfg_we = 0;
  endtask

  task automatic t_reset();
    check(cpu_irq === 1'b0, "R1 cpu_irq", int'(cpu_irq), 0);
    check(vec_valid === 1'b0, "R1 vec_valid", int'(vec_valid), 0);
  endtask

  task automatic t_latency_and_default_base();
    irq_in[1] = 1; tick(2);
    check(cpu_irq === 1'b0, "R9 before third edge", int'(cpu_irq), 0);
    tick(1);
    check(cpu_irq === 1'b1, "R9 at third edge", int'(cpu_irq), 1);
    irq_in[1] = 0; tick(1);
    ack_expect(9, "R2 default base line1");
    check(cpu_irq === 1'b0, "R6 served line quiet", int'(cpu_irq), 0);
    end_service(); tick(3);
    check(cpu_irq === 1'b0, "R6 no re-request", int'(cpu_irq), 0);
  endtask

  task automatic t_level_held();
    irq_in[3] = 1; tick(4);
    ack_expect(11, "R2 line3");
    end_service(); tick(10);
    check(cpu_irq === 1'b0, "R9 held level no retrigger", int'(cpu_irq), 0);
    irq_in[3] = 0; tick(3);
  endtask

  task automatic t_priority();
    pulse_lines(8'b0010_0100);
    ack_expect(10, "R5 line2 before line5");
    check(cpu_irq === 1'b0, "R7 lower blocked", int'(cpu_irq), 0);
    end_service();
    check(cpu_irq === 1'b1, "R8 eos unblocks", int'(cpu_irq), 1);
    ack_expect(13, "R5 line5 second");
    end_service();
  endtask

  task automatic t_nesting();
    pulse_lines(8'b0001_0000);
    ack_expect(12, "R2 line4");
    pulse_lines(8'b0000_0010);
    check(cpu_irq === 1'b1, "R7 higher preempts", int'(cpu_irq), 1);
    ack_expect(9, "R7 nested line1");
    end_service();
    pulse_lines(8'b0000_0100);
    check(cpu_irq === 1'b1, "R8 eos cleared line1 only", int'(cpu_irq), 1);
    ack_expect(10, "R8 line2 served");
    end_service(); end_service();
    check(cpu_irq === 1'b0, "R8 all retired", int'(cpu_irq), 0);
  endtask

  task automatic t_mask();
    write_cfg(1'b0, 8'b0000_1000);
    pulse_lines(8'b0000_1000); tick(4);
    check(cpu_irq === 1'b0, "R3 masked quiet", int'(cpu_irq), 0);
    write_cfg(1'b0, 8'h00);
    check(cpu_irq === 1'b1, "R3 unmask raises", int'(cpu_irq), 1);
    ack_expect(11, "R10 mask write");
    end_service();
    write_cfg(1'b0, 8'b0000_0001);
    pulse_lines(8'b0100_0001);
    ack_expect(14, "R3 masked line0 skipped");
    write_cfg(1'b0, 8'h00);
    check(cpu_irq === 1'b1, "R7 line0 over line6", int'(cpu_irq), 1);
    ack_expect(8, "R2 line0 base");
    end_service(); end_service();
  endtask

  task automatic t_base_wrap();
    write_cfg(1'b1, 8'hFC);
    pulse_lines(8'b1000_0000);
    ack_expect(3, "R10 base write wrap R2");
    end_service();
    write_cfg(1'b1, 8'd8);
  endtask

  task automatic t_stray_ack();
    int_ack = 1; tick(1); int_ack = 0;
    check(vec_valid === 1'b0, "R4 stray ack ignored", int'(vec_valid), 0);
    check(cpu_irq === 1'b0, "R4 stray ack irq", int'(cpu_irq), 0);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(1);
    t_reset();
    t_latency_and_default_base();
    t_level_held();
    t_priority();
    t_nesting();
    t_mask();
    t_base_wrap();
    t_stray_ack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule